// File: doc/BRIEF.md
# Quad-Channel Serial Converter Register Interface

This block is the digital front end of a four-channel, 16-bit converter. A host shifts 24-bit frames into a serial shift register. The host can use either the clock pin or the chip-select pin as the shift strobe. A falling edge on the load strobe copies the 16-bit code into one of four input registers, or into all four when the broadcast bit of the frame is set. The update strobe is active low and level-sensitive. While it is low, the four output (converter) registers follow the input registers. These output registers drive the converter codes.

The serial output presents the bit that leaves the top of the shift register, so several devices can be chained. A separate active-low clear input returns every input register and every output register to a parameterised code. It does not touch the shift register. All serial and strobe pins are asynchronous to the system clock. They pass through two-flop synchronisers, and the system clock must run at least four times faster than the serial clock.

Top module: `quad_dac_ctrl`

## Requirements
- R1: A frame is 24 bits, first bit into the MSB. After a frame, bit 23 holds the high address bit and bit 22 the low address bit. Bit 21 is the broadcast bit, bits 20..16 are ignored, and bits 15..0 are the code.
- R2: On a falling edge of `load_n_i` with the broadcast bit at 0, the code is written only into the input register whose number equals the two address bits. The other three input registers are unchanged.
- R3: On a falling edge of `load_n_i` with the broadcast bit at 1, the code is written into all four input registers, whatever the address bits.
- R4: The shift register takes `sdi_i` in at its LSB on each rising edge of `sclk_i` while `csn_i` is low and `load_n_i` is high.
- R5: A rising edge of `csn_i` while `sclk_i` is low and `load_n_i` is high also shifts one bit.
- R6: The shift register does not change while `sclk_i` and `csn_i` are both high, nor while `load_n_i` is low.
- R7: `sdo_o` is updated from bit 23 of the shift register on each falling edge of the combined strobe (`sclk_i` OR `csn_i`). Just before the i-th shift edge (i from 0) of a following frame, `sdo_o` equals bit 23-i of the previous frame.
- R8: While `ldac_n_i` is low, each output register follows its input register. While it is high, the output registers hold. Channel c appears on `dac_o[16c+15:16c]`.
- R9: While `clr_n_i` is low, all input registers and output registers are forced to `RST_CODE`. The shift register keeps its contents.
- R10: After `rst_n`, all outputs read `RST_CODE` (default 0) and `sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| sclk_i | input | 1 | Serial shift clock |
| csn_i | input | 1 | Chip select, active low, also usable as shift strobe |
| sdi_i | input | 1 | Serial data in |
| load_n_i | input | 1 | Input register load strobe, falling edge |
| ldac_n_i | input | 1 | Output register update, active-low level |
| clr_n_i | input | 1 | Register clear to RST_CODE, active low |
| sdo_o | output | 1 | Serial data out for chaining |
| dac_o | output | 64 | Four 16-bit output codes, channel 0 in the low bits |

## Verification
The bench sweeps every address with several codes, including all-zeros and all-ones, and with junk in the ignored bits. A wrong address decode or field slice would land a code in the wrong channel or corrupt it. Broadcast frames use a non-zero address, so a design that honours the address during a broadcast updates only one channel. Frames are clocked by the clock pin and by the chip-select pin, and strobes are toggled while both pins are high and while load is low. A design that shifts on the wrong edge writes a shifted code on the next load. A chained frame checks `sdo_o` before every shift edge, which exposes an off-by-one output stage. Clear, level-sensitive update and the register hold are checked together, which catches a clear that also wipes the shift register.

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl #(
  parameter int CH = 4,
  parameter int DW = 16,
  parameter int FW = 24,
  parameter logic [DW-1:0] RST_CODE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_i,
  input  logic             csn_i,
  input  logic             sdi_i,
  input  logic             load_n_i,
  input  logic             ldac_n_i,
  input  logic             clr_n_i,
  output logic             sdo_o,
  output logic [CH*DW-1:0] dac_o
);
  localparam int AW = $clog2(CH);
  localparam int QB = FW - AW - 1;
  localparam logic [5:0] IDLE = 6'b010111;

  logic [5:0] m1_q, m2_q;
  logic s_sclk, s_csn, s_sdi, s_load, s_ldac, s_clr;
  logic g_q, load_q, sdo_q;
  logic [FW-1:0] sr_q;
  logic [DW-1:0] in_q  [CH];
  logic [DW-1:0] dac_q [CH];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m1_q <= IDLE;
      m2_q <= IDLE;
    end else begin
      m1_q <= {sclk_i, csn_i, sdi_i, load_n_i, ldac_n_i, clr_n_i};
      m2_q <= m1_q;
    end

  assign {s_sclk, s_csn, s_sdi, s_load, s_ldac, s_clr} = m2_q;

  wire strobe    = s_sclk | s_csn;
  wire shift     = strobe & ~g_q & s_load;
  wire fall      = ~strobe & g_q;
  wire load_fall = load_q & ~s_load;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      g_q    <= 1'b1;
      load_q <= 1'b1;
      sr_q   <= '0;
      sdo_q  <= 1'b0;
    end else begin
      g_q    <= strobe;
      load_q <= s_load;
      if (shift) sr_q  <= {sr_q[FW-2:0], s_sdi};
      if (fall)  sdo_q <= sr_q[FW-1];
    end

  assign sdo_o = sdo_q;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    wire hit = load_fall && (sr_q[QB] || sr_q[FW-1 -: AW] == AW'(c));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        in_q[c]  <= RST_CODE;
        dac_q[c] <= RST_CODE;
      end else if (!s_clr) begin
        in_q[c]  <= RST_CODE;
        dac_q[c] <= RST_CODE;
      end else begin
        if (hit)     in_q[c]  <= sr_q[DW-1:0];
        if (!s_ldac) dac_q[c] <= in_q[c];
      end

    assign dac_o[c*DW +: DW] = dac_q[c];

    a_r9_clear_forces_code: assert property (@(posedge clk) disable iff (!rst_n)
      !s_clr |=> (dac_q[c] == RST_CODE && in_q[c] == RST_CODE));
    a_r8_follow_when_low: assert property (@(posedge clk) disable iff (!rst_n)
      (s_clr && !s_ldac) |=> dac_q[c] == $past(in_q[c]));
    a_r8_hold_when_high: assert property (@(posedge clk) disable iff (!rst_n)
      (s_clr && s_ldac) |=> $stable(dac_q[c]));
    a_r3_broadcast_all: assert property (@(posedge clk) disable iff (!rst_n)
      (load_fall && sr_q[QB] && s_clr) |=> in_q[c] == in_q[0]);
  end

  a_r6_no_shift_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    !s_load |=> $stable(sr_q));
  a_r6_no_shift_both_high: assert property (@(posedge clk) disable iff (!rst_n)
    (s_sclk && s_csn && g_q) |=> $stable(sr_q));
  a_r7_sdo_on_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdo_q));
endmodule

// File: tb/quad_dac_ctrl_tb_top.sv
module quad_dac_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic sclk = 0, csn = 1, sdi = 0, load_n = 1, ldac_n = 1, clr_n = 1;
  logic sdo;
  logic [63:0] dac;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] exp_in [4];
  logic [15:0] exp_dac [4];
  logic [23:0] last_frame = '0;

  always #4 clk = ~clk;

  quad_dac_ctrl dut_i (.clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn),
    .sdi_i(sdi), .load_n_i(load_n), .ldac_n_i(ldac_n), .clr_n_i(clr_n),
    .sdo_o(sdo), .dac_o(dac));

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int c = 0; c < 4; c++) chk(req, 32'(dac[c*16 +: 16]), 32'(exp_dac[c]));
  endtask

  task automatic send(input logic [23:0] f, input bit use_cs, input bit ck_sdo,
                      input logic [23:0] prev);
    if (!use_cs) begin csn = 0; w(5); end
    else begin csn = 0; w(5); end
    for (int i = 0; i < 24; i++) begin
      sdi = f[23-i];
      w(5);
      if (ck_sdo) chk("R7 sdo chain", 32'(sdo), 32'(prev[23-i]));
      if (use_cs) csn = 1; else sclk = 1;
      w(5);
      if (i < 23) begin
        if (use_cs) csn = 0; else sclk = 0;
        w(5);
      end
    end
    if (!use_cs) begin csn = 1; w(5); sclk = 0; w(5); end
    last_frame = f;
  endtask

  task automatic model_load();
    for (int c = 0; c < 4; c++)
      if (last_frame[21] || last_frame[23:22] == 2'(c)) exp_in[c] = last_frame[15:0];
    if (!ldac_n) for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
  endtask

  task automatic pulse_load();
    load_n = 0; w(6); load_n = 1; w(6);
    model_load();
  endtask

  task automatic pulse_ldac();
    ldac_n = 0; w(6); ldac_n = 1; w(6);
    for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] f, g;
    logic [15:0] codes [4];
    codes[0] = 16'h0000; codes[1] = 16'hFFFF; codes[2] = 16'hA5C3; codes[3] = 16'h1234;
    for (int c = 0; c < 4; c++) begin exp_in[c] = 0; exp_dac[c] = 0; end
    w(3); rst_n = 1; w(3);
    chk_all("R10 reset outputs");
    chk("R10 reset sdo", 32'(sdo), 0);

    // R1 R2 R4: address sweep with codes, junk in ignored bits, sclk strobe
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 4; j++) begin
        f = {2'(k), 1'b0, 5'(5'h15 ^ j[4:0]), codes[j] ^ 16'(k * 16'h0101)};
        send(f, (j == 3), 0, 0);
        pulse_load();
        chk_all("R8 hold while update high");
        pulse_ldac();
        chk_all("R2 R1 R4 addressed write");
      end
    end

    // R3: broadcast ignores address
    for (int k = 0; k < 4; k++) begin
      f = {2'(k), 1'b1, 5'h1F, 16'(16'h3C00 + k * 16'h0111)};
      send(f, k[0], 0, 0);
      pulse_load(); pulse_ldac();
      chk_all("R3 broadcast");
    end

    // R5: chip select used as shift strobe
    f = {2'd2, 1'b0, 5'h00, 16'hBEEF};
    send(f, 1, 0, 0);
    pulse_load(); pulse_ldac();
    chk_all("R5 cs strobe");

    // R6: strobes with both high and with load low are ignored
    f = {2'd1, 1'b0, 5'h0A, 16'h5A0F};
    send(f, 0, 0, 0);
    sdi = 1;
    for (int i = 0; i < 3; i++) begin sclk = 1; w(5); sclk = 0; w(5); end
    load_n = 0; w(6); model_load();
    csn = 0; w(5);
    for (int i = 0; i < 3; i++) begin sclk = 1; w(5); sclk = 0; w(5); end
    csn = 1; w(5); load_n = 1; w(6);
    pulse_load(); pulse_ldac();
    chk_all("R6 no shift");

    // R7: chained frame, check sdo before every shift edge
    f = {2'd3, 1'b0, 5'h13, 16'h8001};
    g = {2'd0, 1'b0, 5'h04, 16'h7E7E};
    send(f, 0, 0, 0);
    send(g, 0, 1, f);
    send(f, 1, 1, g);

    // R8: level-sensitive update follows input registers
    ldac_n = 0; w(6);
    for (int c = 0; c < 4; c++) exp_dac[c] = exp_in[c];
    f = {2'd3, 1'b0, 5'h00, 16'hC0DE};
    send(f, 0, 0, 0);
    pulse_load();
    chk_all("R8 follow while low");
    ldac_n = 1; w(6);

    // R9: clear forces code, shift register kept
    clr_n = 0; w(6);
    for (int c = 0; c < 4; c++) begin exp_in[c] = 0; exp_dac[c] = 0; end
    chk_all("R9 clear outputs");
    clr_n = 1; w(6);
    pulse_ldac();
    chk_all("R9 clear input regs");
    pulse_load(); pulse_ldac();
    chk_all("R9 shift register kept");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule